// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Unit

This block is the front end of a small processor whose instructions are packed into bytes. It holds the program counter and presents it to an instruction byte store. The store returns a six-byte window that begins at that address. From the first byte alone the block works out the instruction's class and length. It then pulls out the register specifiers and the 32-bit constant, and computes the address of the next instruction in sequence.

Every cycle the block also grades the instruction at the current address as normal, halt, illegal encoding or out-of-range fetch. While the grade is normal, a small controller steps the program counter forward. The first abnormal grade is latched into a run status, and the counter then freezes until reset. Executing instructions, following branch targets and writing memory belong to later stages.

Top module: `ifetch_unit`

## Requirements
- R1: While reset is asserted at a rising edge, the program counter becomes 0 and the run status becomes AOK (run status and instruction status both encode AOK=0, HLT=1, ADR=2, INS=3).
- R2: The instruction code output equals bits 7:4 of window byte 0, and the function code output equals bits 3:0. Window byte k sits in win_bytes bits 8k+7:8k.
- R3: For instruction codes 2, 3, 4, 5, 6, A and B a register byte follows, and rA and rB are bits 7:4 and bits 3:0 of window byte 1. For every other code, both rA and rB read 0xF.
- R4: The constant is a little-endian 32-bit word. For codes 3, 4 and 5 it comes from window bytes 2 to 5. For codes 7 and 8 it comes from bytes 1 to 4. For all other codes it is 0.
- R5: valP is the PC plus the instruction length. The length is 1 for codes 0, 1 and 9; 2 for codes 2, 6, A and B; 5 for codes 7 and 8; 6 for codes 3, 4 and 5.
- R6: The instruction status is INS, with valP = PC+1, when the code is above B, or when the function code is nonzero for a code other than 6 and 7, or is above 3 for code 6, or is above 6 for code 7.
- R7: The instruction status is ADR when the PC is at or beyond MEM_BYTES; this takes priority over INS. It is also ADR when the PC plus the length of a legal instruction exceeds MEM_BYTES.
- R8: A halt instruction (code 1, function 0) that lies inside memory gives instruction status HLT. Every other legal, in-range instruction gives AOK.
- R9: While the run status is AOK and the instruction status is AOK, each rising edge loads valP into the PC.
- R10: While the run status is AOK and the instruction status is not AOK, the next edge copies the instruction status into the run status and leaves the PC unchanged. Once the run status is not AOK, the PC and run status both hold until reset, whatever the window holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | output | 32 | Current program counter, address of window byte 0 |
| win_bytes | input | 48 | Six instruction bytes starting at fetch_pc, byte k in bits 8k+7:8k |
| icode | output | 4 | Instruction code |
| ifun | output | 4 | Function code |
| ra | output | 4 | First register specifier, 0xF when absent |
| rb | output | 4 | Second register specifier, 0xF when absent |
| valc | output | 32 | Decoded constant or destination |
| valp | output | 32 | Address of the next sequential instruction |
| inst_stat | output | 2 | Status of the instruction at fetch_pc |
| run_stat | output | 2 | Sticky run status |

## Verification
A straight-line program with one instance of each instruction class walks every length and every constant position. It separates the one-, two-, five- and six-byte paths, as well as the register-byte and no-register-byte constant offsets. A program whose second instruction has a bad function code freezes the unit. The window is then rewritten under the frozen PC, so several illegal and legal encodings are graded while the PC and run status are shown to hold. Two runs of nops up to the memory edge place a six-byte instruction either exactly at the limit or one byte over it, and then continue past the end. These runs tell apart the span check, the start-address check and its priority over decoding.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

    typedef enum logic [1:0] {
        ST_AOK = 2'd0,
        ST_HLT = 2'd1,
        ST_ADR = 2'd2,
        ST_INS = 2'd3
    } ifu_stat_e;

    localparam logic [3:0] OP_NOP   = 4'h0;
    localparam logic [3:0] OP_HALT  = 4'h1;
    localparam logic [3:0] OP_RRMV  = 4'h2;
    localparam logic [3:0] OP_IRMV  = 4'h3;
    localparam logic [3:0] OP_RMMV  = 4'h4;
    localparam logic [3:0] OP_MRMV  = 4'h5;
    localparam logic [3:0] OP_ALU   = 4'h6;
    localparam logic [3:0] OP_JUMP  = 4'h7;
    localparam logic [3:0] OP_CALL  = 4'h8;
    localparam logic [3:0] OP_RET   = 4'h9;
    localparam logic [3:0] OP_PUSH  = 4'hA;
    localparam logic [3:0] OP_POP   = 4'hB;
    localparam logic [3:0] REG_NONE = 4'hF;

    localparam int WIN_BYTES = 6;
    localparam int LEN_W     = 3;

    typedef struct packed {
        logic [3:0]  icode;
        logic [3:0]  ifun;
        logic [3:0]  ra;
        logic [3:0]  rb;
        logic [31:0] valc;
        logic        has_reg;
        logic        has_const;
        logic        op_ok;
    } ifu_fields_t;

    // Legal instruction/function code pairs.
    function automatic logic op_legal(input logic [3:0] code, input logic [3:0] fn);
        case (code)
            OP_ALU:  return fn <= 4'd3;
            OP_JUMP: return fn <= 4'd6;
            OP_NOP, OP_HALT, OP_RRMV, OP_IRMV, OP_RMMV, OP_MRMV,
            OP_CALL, OP_RET, OP_PUSH, OP_POP: return fn == 4'd0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic op_has_reg(input logic [3:0] code);
        case (code)
            OP_RRMV, OP_IRMV, OP_RMMV, OP_MRMV, OP_ALU, OP_PUSH, OP_POP: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic op_has_const(input logic [3:0] code);
        case (code)
            OP_IRMV, OP_RMMV, OP_MRMV, OP_JUMP, OP_CALL: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] op_length(input logic reg_b, input logic const_b);
        return LEN_W'(1) + (reg_b ? LEN_W'(1) : LEN_W'(0)) + (const_b ? LEN_W'(4) : LEN_W'(0));
    endfunction

endpackage

// File: rtl/ifu_field_split.sv
module ifu_field_split
    import ifu_pkg::*;
(
    input  logic [8*WIN_BYTES-1:0] win,
    output ifu_fields_t            fields
);
    localparam int CONST_BYTES = 4;

    logic [7:0] wbyte [WIN_BYTES];

    for (genvar k = 0; k < WIN_BYTES; k++) begin : g_bytes
        assign wbyte[k] = win[8*k +: 8];
    end

    logic [31:0] const_after_reg;
    logic [31:0] const_no_reg;

    for (genvar k = 0; k < CONST_BYTES; k++) begin : g_const
        assign const_after_reg[8*k +: 8] = wbyte[k+2];
        assign const_no_reg[8*k +: 8]    = wbyte[k+1];
    end

    logic [3:0] code;
    logic [3:0] fn;
    logic       legal;
    logic       reg_b;
    logic       const_b;

    always_comb begin
        code    = wbyte[0][7:4];
        fn      = wbyte[0][3:0];
        legal   = op_legal(code, fn);
        reg_b   = legal && op_has_reg(code);
        const_b = legal && op_has_const(code);

        fields.icode     = code;
        fields.ifun      = fn;
        fields.op_ok     = legal;
        fields.has_reg   = reg_b;
        fields.has_const = const_b;
        fields.ra        = reg_b ? wbyte[1][7:4] : REG_NONE;
        fields.rb        = reg_b ? wbyte[1][3:0] : REG_NONE;
        if (!const_b)
            fields.valc = '0;
        else if (reg_b)
            fields.valc = const_after_reg;
        else
            fields.valc = const_no_reg;
    end

endmodule

// File: rtl/ifu_status_eval.sv
module ifu_status_eval
    import ifu_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int MEM_BYTES = 256
) (
    input  logic [PC_W-1:0] pc,
    input  logic [3:0]      icode,
    input  logic            op_ok,
    input  logic            has_reg,
    input  logic            has_const,
    output logic [PC_W-1:0] valp,
    output ifu_stat_e       inst_stat
);
    localparam logic [PC_W:0] MEM_LIM = (PC_W+1)'(MEM_BYTES);

    logic [LEN_W-1:0] len;
    logic [PC_W:0]    span_end;
    logic             start_bad;
    logic             span_bad;

    always_comb begin
        len       = op_length(has_reg, has_const);
        span_end  = {1'b0, pc} + (PC_W+1)'(len);
        start_bad = {1'b0, pc} >= MEM_LIM;
        span_bad  = span_end > MEM_LIM;
        valp      = pc + PC_W'(len);

        if (start_bad)
            inst_stat = ST_ADR;
        else if (!op_ok)
            inst_stat = ST_INS;
        else if (span_bad)
            inst_stat = ST_ADR;
        else if (icode == OP_HALT)
            inst_stat = ST_HLT;
        else
            inst_stat = ST_AOK;
    end

endmodule

// File: rtl/ifu_pc_ctrl.sv
module ifu_pc_ctrl
    import ifu_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] valp,
    input  ifu_stat_e       inst_stat,
    output logic [PC_W-1:0] pc,
    output ifu_stat_e       run_stat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= '0;
            run_stat <= ST_AOK;
        end else if (run_stat == ST_AOK) begin
            if (inst_stat == ST_AOK)
                pc <= valp;
            else
                run_stat <= inst_stat;
        end
    end

endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit
    import ifu_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int MEM_BYTES = 256
) (
    input  logic                    clk,
    input  logic                    rst,
    output logic [PC_W-1:0]         fetch_pc,
    input  logic [8*WIN_BYTES-1:0]  win_bytes,
    output logic [3:0]              icode,
    output logic [3:0]              ifun,
    output logic [3:0]              ra,
    output logic [3:0]              rb,
    output logic [31:0]             valc,
    output logic [PC_W-1:0]         valp,
    output logic [1:0]              inst_stat,
    output logic [1:0]              run_stat
);
    ifu_fields_t     fields;
    ifu_stat_e       cur_stat;
    ifu_stat_e       run_q;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] next_pc;

    ifu_field_split u_split (
        .win    (win_bytes),
        .fields (fields)
    );

    ifu_status_eval #(
        .PC_W      (PC_W),
        .MEM_BYTES (MEM_BYTES)
    ) u_eval (
        .pc        (pc_q),
        .icode     (fields.icode),
        .op_ok     (fields.op_ok),
        .has_reg   (fields.has_reg),
        .has_const (fields.has_const),
        .valp      (next_pc),
        .inst_stat (cur_stat)
    );

    ifu_pc_ctrl #(
        .PC_W (PC_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .valp      (next_pc),
        .inst_stat (cur_stat),
        .pc        (pc_q),
        .run_stat  (run_q)
    );

    assign fetch_pc  = pc_q;
    assign icode     = fields.icode;
    assign ifun      = fields.ifun;
    assign ra        = fields.ra;
    assign rb        = fields.rb;
    assign valc      = fields.valc;
    assign valp      = next_pc;
    assign inst_stat = cur_stat;
    assign run_stat  = run_q;

endmodule

// File: rtl/ifu_checker.sv
module ifu_checker #(
    parameter int PC_W      = 32,
    parameter int MEM_BYTES = 256
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] fetch_pc,
    input logic [PC_W-1:0] valp,
    input logic [3:0]      icode,
    input logic [3:0]      ra,
    input logic [3:0]      rb,
    input logic [1:0]      inst_stat,
    input logic [1:0]      run_stat
);
    localparam logic [PC_W:0] LIM = (PC_W+1)'(MEM_BYTES);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (fetch_pc == '0 && run_stat == 2'd0));

    p_no_reg_field_r3: assert property (@(posedge clk) disable iff (rst)
        (inst_stat == 2'd0 && (icode == 4'h0 || icode == 4'h7 || icode == 4'h8 || icode == 4'h9))
        |-> (ra == 4'hF && rb == 4'hF));

    p_length_set_r5: assert property (@(posedge clk) disable iff (rst)
        (inst_stat == 2'd0 || inst_stat == 2'd1)
        |-> ((valp - fetch_pc) == PC_W'(1) || (valp - fetch_pc) == PC_W'(2) ||
             (valp - fetch_pc) == PC_W'(5) || (valp - fetch_pc) == PC_W'(6)));

    p_in_bounds_r7: assert property (@(posedge clk) disable iff (rst)
        (inst_stat == 2'd0) |-> ({1'b0, valp} <= LIM));

    p_advance_r9: assert property (@(posedge clk) disable iff (rst)
        (run_stat == 2'd0 && inst_stat == 2'd0) |=> (fetch_pc == $past(valp)));

    p_capture_r10: assert property (@(posedge clk) disable iff (rst)
        (run_stat == 2'd0 && inst_stat != 2'd0)
        |=> (run_stat == $past(inst_stat) && fetch_pc == $past(fetch_pc)));

    p_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (run_stat != 2'd0) |=> ($stable(run_stat) && $stable(fetch_pc)));

endmodule

bind ifetch_unit ifu_checker #(
    .PC_W      (PC_W),
    .MEM_BYTES (MEM_BYTES)
) u_ifu_checker (
    .clk       (clk),
    .rst       (rst),
    .fetch_pc  (fetch_pc),
    .valp      (valp),
    .icode     (icode),
    .ra        (ra),
    .rb        (rb),
    .inst_stat (inst_stat),
    .run_stat  (run_stat)
);

// File: tb/test_ifetch_unit.sv
`timescale 1ns/1ps
module test_ifetch_unit;
    localparam int PC_W = 32;
    localparam int MEM  = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc;
    logic [47:0] win_bytes;
    logic [3:0]  icode, ifun, ra, rb;
    logic [31:0] valc, valp;
    logic [1:0]  inst_stat, run_stat;

    logic [7:0] mem [MEM];
    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    ifetch_unit #(.PC_W(PC_W), .MEM_BYTES(MEM)) i_ifetch_unit (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .win_bytes(win_bytes),
        .icode(icode), .ifun(ifun), .ra(ra), .rb(rb), .valc(valc),
        .valp(valp), .inst_stat(inst_stat), .run_stat(run_stat)
    );

    always_comb begin
        for (int k = 0; k < 6; k++) begin
            if (fetch_pc + 32'(k) < 32'(MEM))
                win_bytes[8*k +: 8] = mem[fetch_pc + 32'(k)];
            else
                win_bytes[8*k +: 8] = 8'h00;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < MEM; i++) mem[i] = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_inst(input string req, input logic [31:0] pc_e, input logic [3:0] ic,
                              input logic [3:0] fn, input logic [3:0] a, input logic [3:0] b,
                              input logic [31:0] c, input logic [31:0] p, input logic [1:0] st);
        check({req, " pc"}, fetch_pc, pc_e);
        check("R2 icode", 32'(icode), 32'(ic));
        check("R2 ifun", 32'(ifun), 32'(fn));
        check("R3 ra", 32'(ra), 32'(a));
        check("R3 rb", 32'(rb), 32'(b));
        check("R4 valc", valc, c);
        check("R5 valp", valp, p);
        check({req, " inst_stat"}, 32'(inst_stat), 32'(st));
    endtask

    task automatic put(input int at, input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                       input logic [7:0] b3, input logic [7:0] b4, input logic [7:0] b5, input int n);
        logic [7:0] bs [6];
        bs = '{b0, b1, b2, b3, b4, b5};
        for (int i = 0; i < n; i++) mem[at + i] = bs[i];
    endtask

    // R1 reset state
    task automatic t_reset();
        clear_mem();
        do_reset();
        check("R1 pc after reset", fetch_pc, 32'd0);
        check("R1 run_stat after reset", 32'(run_stat), 32'd0);
    endtask

    // R2..R5, R8, R9, R10: one of each class, walked in order
    task automatic t_sequence();
        clear_mem();
        put(0,  8'h00, 0, 0, 0, 0, 0, 1);
        put(1,  8'h20, 8'h43, 0, 0, 0, 0, 2);
        put(3,  8'h30, 8'hF2, 8'hcd, 8'hab, 8'h00, 8'h00, 6);
        put(9,  8'h50, 8'h15, 8'hf4, 8'hff, 8'hff, 8'hff, 6);
        put(15, 8'h63, 8'h06, 0, 0, 0, 0, 2);
        put(17, 8'h70, 8'h78, 8'h56, 8'h34, 8'h12, 0, 5);
        put(22, 8'h80, 8'h00, 8'h01, 8'h00, 8'h00, 0, 5);
        put(27, 8'h90, 0, 0, 0, 0, 0, 1);
        put(28, 8'hA0, 8'h2F, 0, 0, 0, 0, 2);
        put(30, 8'hB0, 8'h3F, 0, 0, 0, 0, 2);
        put(32, 8'h10, 0, 0, 0, 0, 0, 1);
        do_reset();
        check_inst("R9 nop",   0,  4'h0, 4'h0, 4'hF, 4'hF, 32'h0, 1, 2'd0); step(1);
        check_inst("R9 rrmv",  1,  4'h2, 4'h0, 4'h4, 4'h3, 32'h0, 3, 2'd0); step(1);
        check_inst("R9 irmv",  3,  4'h3, 4'h0, 4'hF, 4'h2, 32'h0000abcd, 9, 2'd0); step(1);
        check_inst("R9 mrmv",  9,  4'h5, 4'h0, 4'h1, 4'h5, 32'hfffffff4, 15, 2'd0); step(1);
        check_inst("R9 alu",   15, 4'h6, 4'h3, 4'h0, 4'h6, 32'h0, 17, 2'd0); step(1);
        check_inst("R9 jump",  17, 4'h7, 4'h0, 4'hF, 4'hF, 32'h12345678, 22, 2'd0); step(1);
        check_inst("R9 call",  22, 4'h8, 4'h0, 4'hF, 4'hF, 32'h00000100, 27, 2'd0); step(1);
        check_inst("R9 ret",   27, 4'h9, 4'h0, 4'hF, 4'hF, 32'h0, 28, 2'd0); step(1);
        check_inst("R9 push",  28, 4'hA, 4'h0, 4'h2, 4'hF, 32'h0, 30, 2'd0); step(1);
        check_inst("R9 pop",   30, 4'hB, 4'h0, 4'h3, 4'hF, 32'h0, 32, 2'd0); step(1);
        check_inst("R8 halt",  32, 4'h1, 4'h0, 4'hF, 4'hF, 32'h0, 33, 2'd1);
        check("R8 run_stat before capture", 32'(run_stat), 32'd0);
        step(1);
        check("R10 halt captured", 32'(run_stat), 32'd1);
        check("R10 pc held at halt", fetch_pc, 32'd32);
        step(3);
        check("R10 halt sticky", 32'(run_stat), 32'd1);
        check("R10 pc still held", fetch_pc, 32'd32);
    endtask

    // R6 illegal encodings, R10 freeze while the window changes, R1 reset recovery
    task automatic t_illegal();
        clear_mem();
        put(0, 8'h00, 0, 0, 0, 0, 0, 1);
        put(1, 8'h65, 8'h00, 0, 0, 0, 0, 2);
        do_reset();
        check("R9 nop before bad op", 32'(inst_stat), 32'd0);
        step(1);
        check("R6 alu fn 5", 32'(inst_stat), 32'd3);
        check("R6 valp pc+1", valp, 32'd2);
        step(1);
        check("R10 INS captured", 32'(run_stat), 32'd3);
        check("R10 pc held on INS", fetch_pc, 32'd1);
        mem[1] = 8'hC0;
        #1 check("R6 code C", 32'(inst_stat), 32'd3);
        mem[1] = 8'h21;
        #1 check("R6 rrmv fn 1", 32'(inst_stat), 32'd3);
        mem[1] = 8'h77;
        #1 check("R6 jump fn 7", 32'(inst_stat), 32'd3);
        mem[1] = 8'h76;
        #1 check("R6 jump fn 6 legal", 32'(inst_stat), 32'd0);
        step(2);
        check("R10 pc frozen despite legal op", fetch_pc, 32'd1);
        check("R10 run_stat frozen", 32'(run_stat), 32'd3);
        do_reset();
        check("R1 pc after re-reset", fetch_pc, 32'd0);
        check("R1 run_stat after re-reset", 32'(run_stat), 32'd0);
    endtask

    // R7 span past the end of memory, one byte over
    task automatic t_span_over();
        clear_mem();
        put(59, 8'h30, 8'hF1, 8'h01, 8'h02, 8'h03, 0, 5);
        do_reset();
        step(59);
        check("R7 pc at 59", fetch_pc, 32'd59);
        check("R7 six bytes over edge", 32'(inst_stat), 32'd2);
        step(1);
        check("R10 ADR captured", 32'(run_stat), 32'd2);
        check("R10 pc held on ADR", fetch_pc, 32'd59);
    endtask

    // R7 exact fit, then start address beyond memory
    task automatic t_span_fit();
        clear_mem();
        put(58, 8'h30, 8'hF1, 8'h04, 8'h03, 8'h02, 8'h01, 6);
        do_reset();
        step(58);
        check("R7 exact fit ok", 32'(inst_stat), 32'd0);
        check("R4 valc at edge", valc, 32'h01020304);
        check("R5 valp at edge", valp, 32'd64);
        step(1);
        check("R9 pc reached limit", fetch_pc, 32'd64);
        check("R7 start beyond memory", 32'(inst_stat), 32'd2);
        check("R10 run_stat still AOK", 32'(run_stat), 32'd0);
        step(1);
        check("R10 start ADR captured", 32'(run_stat), 32'd2);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        clear_mem();
        t_reset();
        t_sequence();
        t_illegal();
        t_span_over();
        t_span_fit();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule